// File: doc/BRIEF.md
# DMA Channel Priority and Interrupt Register Block

This block holds the shared register state of a seven-channel DMA engine. It owns no data path. It keeps one word with a priority value and a run-permission bit for each channel, and one interrupt word. The interrupt word holds the per-channel interrupt enables, the per-channel completion flags, a global enable, a force bit and six bits of spare storage. From these fields the block derives one combined interrupt line.

Software reaches the two words through a simple 32-bit port. There is a write strobe with an offset and data. The read data follows the offset combinationally. Each channel engine reports a finished transfer with a one-cycle pulse on its own completion input. The pulse latches that channel's flag. Software acknowledges a flag by writing a 1 to the flag's bit.

The combined interrupt is held in a register. It is recomputed whenever the interrupt word is written or any completion pulse arrives, so it always reflects the newest state. A separate one-cycle pulse marks each moment at which the combined interrupt turns on.

Top module: `dmareg_top`

## Requirements
- R1: After reset, offset 0xF0 reads with channel n's 3-bit priority equal to n+1 and every run-permission bit at 0. Offset 0xF4 reads as zero, and `irq_out` and `irq_event` are 0.
- R2: A write to offset 0xF0 stores a 4-bit group for each channel n at bits 4n..4n+3. The low 3 bits are the priority and bit 4n+3 is the run permission. Bits 28..31 always read 0.
- R3: A write to offset 0xF4 stores spare bits 0..5, channel interrupt enables at bits 16..22 (channel n at 16+n) and the global enable at bit 23, all read back unchanged. The force bit, bit 15, is stored but always reads 0.
- R4: A one-cycle pulse on `done_pulse[n]` sets channel n's flag. The flag reads at bit 24+n of offset 0xF4 from the next cycle on.
- R5: Writing 1 to bit 24+n of offset 0xF4 clears channel n's flag. Writing 0 there leaves it unchanged, and the enable and control fields of the same write never alter any flag.
- R6: When a completion pulse and a clearing write hit the same channel in one cycle, the flag ends up set.
- R7: The master flag, read at bit 31 of offset 0xF4 and driven on `irq_out`, equals force OR (global enable AND the OR over channels of flag AND enable). It is evaluated with the state that results from each interrupt-word write or completion pulse, and it takes effect on the following cycle.
- R8: `irq_event` is high for exactly one cycle, the first cycle in which `irq_out` is 1 after being 0.
- R9: Writes to any offset other than 0xF0 and 0xF4 change nothing, and reads of such offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| done_pulse | input | 7 | Per-channel completion pulses |
| irq_out | output | 1 | Registered master interrupt flag |
| irq_event | output | 1 | One-cycle pulse when `irq_out` rises |

## Verification
Corruption of a flag, an enable or a priority group shows up at `reg_rdata` in the first cycle after the disturbing edge, because every field is visible through a read with no latency. A master flag computed from stale values instead of the post-update state shows as an `irq_out` mismatch one cycle after the write or pulse that should have moved it. A missed or repeated event pulse shows on `irq_event` in that same cycle. Comparing every port against a behavioural model on every clock therefore exposes a wrong internal state within one cycle of its cause.

// File: rtl/dmareg_pkg.sv
`timescale 1ns/1ps
package dmareg_pkg;
   // Bit positions within the interrupt word; channel software decodes these.
   localparam int FORCE_BIT  = 15;
   localparam int EN_LSB     = 16;
   localparam int GEN_BIT    = 23;
   localparam int FLAG_LSB   = 24;
   localparam int MASTER_BIT = 31;
   localparam int WORD_W     = 32;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_IRQ  = 2'd2
   } regsel_e;
endpackage

// File: rtl/dmareg_addr_dec.sv
`timescale 1ns/1ps
module dmareg_addr_dec
   import dmareg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'hF0,
   parameter logic [ADDR_W-1:0] IRQ_OFS  = 'hF4
) (
   input  logic [ADDR_W-1:0] addr,
   output regsel_e           sel
);
   if (CTRL_OFS == IRQ_OFS) begin : g_bad_ofs
      $error("dmareg_addr_dec: the two offsets must differ");
   end

   always_comb begin
      if (addr == CTRL_OFS)     sel = SEL_CTRL;
      else if (addr == IRQ_OFS) sel = SEL_IRQ;
      else                      sel = SEL_NONE;
   end
endmodule

// File: rtl/dmareg_ctrl_bank.sv
`timescale 1ns/1ps
module dmareg_ctrl_bank
   import dmareg_pkg::*;
#(
   parameter int NUM_CH = 7,
   parameter int PRIO_W = 3
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [WORD_W-1:0]             wdata,
   output logic [WORD_W-1:0]             rd_word
);
   localparam int GRP_W  = PRIO_W + 1;
   localparam int USED_W = NUM_CH * GRP_W;

   if (USED_W > WORD_W) begin : g_bad_width
      $error("dmareg_ctrl_bank: channel groups exceed the word");
   end
   if (NUM_CH >= (1 << PRIO_W)) begin : g_bad_prio
      $error("dmareg_ctrl_bank: reset priority n+1 does not fit PRIO_W");
   end

   logic [NUM_CH-1:0][PRIO_W-1:0] prio_q;
   logic [NUM_CH-1:0]             run_q;
   logic                          unused_wdata;

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int n = 0; n < NUM_CH; n++) begin
            prio_q[n] <= PRIO_W'(n + 1);
            run_q[n]  <= 1'b0;
         end
      end else if (wr_en) begin
         for (int n = 0; n < NUM_CH; n++) begin
            prio_q[n] <= wdata[n*GRP_W +: PRIO_W];
            run_q[n]  <= wdata[n*GRP_W + PRIO_W];
         end
      end
   end

   for (genvar n = 0; n < NUM_CH; n++) begin : g_grp
      assign rd_word[n*GRP_W +: GRP_W] = {run_q[n], prio_q[n]};
   end
   if (USED_W < WORD_W) begin : g_pad
      assign rd_word[WORD_W-1:USED_W] = '0;
   end

   // R2: stored group follows the written group one cycle later
   a_r2_group_store: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_word[USED_W-1:0] == $past(wdata[USED_W-1:0]));
endmodule

// File: rtl/dmareg_irq_bank.sv
`timescale 1ns/1ps
module dmareg_irq_bank
   import dmareg_pkg::*;
#(
   parameter int NUM_CH  = 7,
   parameter int SPARE_W = 6
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [WORD_W-1:0]   wdata,
   input  logic [NUM_CH-1:0]   done,
   output logic [SPARE_W-1:0]  spare_q,
   output logic                force_q,
   output logic [NUM_CH-1:0]   en_q,
   output logic                gen_q,
   output logic [NUM_CH-1:0]   flags_q,
   output logic                force_d,
   output logic [NUM_CH-1:0]   en_d,
   output logic                gen_d,
   output logic [NUM_CH-1:0]   flags_d
);
   if (NUM_CH > MASTER_BIT - FLAG_LSB) begin : g_bad_ch
      $error("dmareg_irq_bank: flag field overlaps the master bit");
   end
   if (NUM_CH > GEN_BIT - EN_LSB) begin : g_bad_en
      $error("dmareg_irq_bank: enable field overlaps the global enable");
   end
   if (SPARE_W > FORCE_BIT) begin : g_bad_spare
      $error("dmareg_irq_bank: spare field overlaps the force bit");
   end

   logic [SPARE_W-1:0] spare_d;
   logic [NUM_CH-1:0]  clr_mask;
   logic               unused_wdata;

   assign unused_wdata = ^wdata;
   assign clr_mask     = wr_en ? wdata[FLAG_LSB +: NUM_CH] : '0;

   always_comb begin
      spare_d = spare_q;
      force_d = force_q;
      en_d    = en_q;
      gen_d   = gen_q;
      if (wr_en) begin
         spare_d = wdata[SPARE_W-1:0];
         force_d = wdata[FORCE_BIT];
         en_d    = wdata[EN_LSB +: NUM_CH];
         gen_d   = wdata[GEN_BIT];
      end
      // set from a completion pulse wins over an acknowledge in the same cycle
      flags_d = (flags_q & ~clr_mask) | done;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spare_q <= '0;
         force_q <= 1'b0;
         en_q    <= '0;
         gen_q   <= 1'b0;
         flags_q <= '0;
      end else begin
         spare_q <= spare_d;
         force_q <= force_d;
         en_q    <= en_d;
         gen_q   <= gen_d;
         flags_q <= flags_d;
      end
   end

   // R4, R6: every pulsed channel reads as set on the next cycle
   a_r4_pulse_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (|done) |=> ((flags_q & $past(done)) == $past(done)));
   // R5: a flag that was not acknowledged keeps its value
   a_r5_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(flags_q) & ~$past(clr_mask)) & ~flags_q) == '0));
   // R5: flags only rise through a completion pulse
   a_r5_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((flags_q & ~$past(flags_q)) & ~$past(done)) == '0));
endmodule

// File: rtl/dmareg_irq_master.sv
`timescale 1ns/1ps
module dmareg_irq_master #(
   parameter int NUM_CH = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              update,
   input  logic              force_d,
   input  logic              gen_d,
   input  logic [NUM_CH-1:0] flags_d,
   input  logic [NUM_CH-1:0] en_d,
   output logic              irq_q,
   output logic              event_q
);
   logic master_d;

   assign master_d = update ? (force_d | (gen_d & (|(flags_d & en_d)))) : irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q   <= 1'b0;
         event_q <= 1'b0;
      end else begin
         irq_q   <= master_d;
         event_q <= master_d & ~irq_q;
      end
   end

   // R7: without an update the master flag holds
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !update |=> $stable(irq_q));
   // R8: the event marks every rise and only a rise
   a_r8_event_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q) |-> event_q);
   a_r8_event_needs_rise: assert property (@(posedge clk) disable iff (!rst_n)
      event_q |-> (irq_q && !$past(irq_q)));
   a_r8_event_single: assert property (@(posedge clk) disable iff (!rst_n)
      event_q |=> !event_q);
endmodule

// File: rtl/dmareg_top.sv
`timescale 1ns/1ps
module dmareg_top
   import dmareg_pkg::*;
#(
   parameter int NUM_CH  = 7,
   parameter int PRIO_W  = 3,
   parameter int SPARE_W = 6,
   parameter int ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'hF0,
   parameter logic [ADDR_W-1:0] IRQ_OFS  = 'hF4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [NUM_CH-1:0] done_pulse,
   output logic              irq_out,
   output logic              irq_event
);
   regsel_e            sel;
   logic               ctrl_wr;
   logic               irq_wr;
   logic [WORD_W-1:0]  ctrl_word;
   logic [WORD_W-1:0]  irq_word;
   logic [SPARE_W-1:0] spare_q;
   logic               force_q, gen_q, force_d, gen_d;
   logic [NUM_CH-1:0]  en_q, flags_q, en_d, flags_d;

   dmareg_addr_dec #(.ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .IRQ_OFS(IRQ_OFS)) u_dec (
      .addr (reg_addr),
      .sel  (sel)
   );

   assign ctrl_wr = reg_wr && (sel == SEL_CTRL);
   assign irq_wr  = reg_wr && (sel == SEL_IRQ);

   dmareg_ctrl_bank #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ctrl_wr),
      .wdata   (reg_wdata),
      .rd_word (ctrl_word)
   );

   dmareg_irq_bank #(.NUM_CH(NUM_CH), .SPARE_W(SPARE_W)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (irq_wr),
      .wdata   (reg_wdata),
      .done    (done_pulse),
      .spare_q (spare_q),
      .force_q (force_q),
      .en_q    (en_q),
      .gen_q   (gen_q),
      .flags_q (flags_q),
      .force_d (force_d),
      .en_d    (en_d),
      .gen_d   (gen_d),
      .flags_d (flags_d)
   );

   dmareg_irq_master #(.NUM_CH(NUM_CH)) u_master (
      .clk     (clk),
      .rst_n   (rst_n),
      .update  (irq_wr | (|done_pulse)),
      .force_d (force_d),
      .gen_d   (gen_d),
      .flags_d (flags_d),
      .en_d    (en_d),
      .irq_q   (irq_out),
      .event_q (irq_event)
   );

   always_comb begin
      irq_word                        = '0;
      irq_word[SPARE_W-1:0]           = spare_q;
      irq_word[EN_LSB +: NUM_CH]      = en_q;
      irq_word[GEN_BIT]               = gen_q;
      irq_word[FLAG_LSB +: NUM_CH]    = flags_q;
      irq_word[MASTER_BIT]            = irq_out;
   end

   always_comb begin
      unique case (sel)
         SEL_CTRL: reg_rdata = ctrl_word;
         SEL_IRQ:  reg_rdata = irq_word;
         default:  reg_rdata = '0;
      endcase
   end

   // R7: the registered master agrees with the stored fields
   a_r7_master_formula: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == (force_q | (gen_q & (|(flags_q & en_q)))));
   // R2: top nibble of the control word is always zero
   a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_CTRL) |-> (reg_rdata[31:28] == 4'h0));
   // R3: force bit never reads back
   a_r3_force_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_IRQ) |-> !reg_rdata[FORCE_BIT]);
   // R9: unmapped offsets read zero
   a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (reg_rdata == '0));
endmodule

// File: tb/dmareg_top_tb.sv
`timescale 1ns/1ps
module dmareg_top_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        reg_wr;
   logic [7:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic [6:0]  done_pulse;
   logic        irq_out;
   logic        irq_event;

   int checks = 0;
   int failures = 0;

   // behavioural reference state
   int m_prio[7];
   bit m_run[7];
   bit m_en[7];
   bit m_flag[7];
   bit [5:0] m_spare;
   bit m_force, m_gen, m_master, m_event;

   always #5 clk = ~clk;

   dmareg_top u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .done_pulse (done_pulse),
      .irq_out    (irq_out),
      .irq_event  (irq_event)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int n = 0; n < 7; n++) begin
            m_prio[n] = n + 1; m_run[n] = 0; m_en[n] = 0; m_flag[n] = 0;
         end
         m_spare = 0; m_force = 0; m_gen = 0; m_master = 0; m_event = 0;
      end else begin
         bit old, any, upd;
         old = m_master;
         upd = 0;
         if (reg_wr && reg_addr == 8'hF0) begin
            for (int n = 0; n < 7; n++) begin
               m_prio[n] = reg_wdata[4*n +: 3];
               m_run[n]  = reg_wdata[4*n+3];
            end
         end
         if (reg_wr && reg_addr == 8'hF4) begin
            upd = 1;
            m_spare = reg_wdata[5:0];
            m_force = reg_wdata[15];
            m_gen   = reg_wdata[23];
            for (int n = 0; n < 7; n++) begin
               m_en[n] = reg_wdata[16+n];
               if (reg_wdata[24+n]) m_flag[n] = 0;
            end
         end
         for (int n = 0; n < 7; n++) begin
            if (done_pulse[n]) begin m_flag[n] = 1; upd = 1; end
         end
         if (upd) begin
            any = 0;
            for (int n = 0; n < 7; n++) any |= m_flag[n] & m_en[n];
            m_master = m_force | (m_gen & any);
         end
         m_event = m_master & !old;
      end
   end

   function automatic logic [31:0] exp_read(logic [7:0] a);
      logic [31:0] r = '0;
      if (a == 8'hF0) begin
         for (int n = 0; n < 7; n++) begin
            r[4*n +: 3] = 3'(m_prio[n]);
            r[4*n+3]    = m_run[n];
         end
      end else if (a == 8'hF4) begin
         r[5:0] = m_spare;
         r[23]  = m_gen;
         r[31]  = m_master;
         for (int n = 0; n < 7; n++) begin
            r[16+n] = m_en[n];
            r[24+n] = m_flag[n];
         end
      end
      return r;
   endfunction

   task automatic check_ports(string req);
      logic [31:0] er = exp_read(reg_addr);
      checks++;
      if (reg_rdata !== er) begin
         failures++;
         $display("FAIL %s rdata@%h actual=%h expected=%h", req, reg_addr, reg_rdata, er);
      end
      checks++;
      if (irq_out !== m_master) begin
         failures++;
         $display("FAIL %s irq_out actual=%b expected=%b", req, irq_out, m_master);
      end
      checks++;
      if (irq_event !== m_event) begin
         failures++;
         $display("FAIL %s irq_event actual=%b expected=%b", req, irq_event, m_event);
      end
   endtask

   // one clock: drive, let the edge happen, compare at the falling edge
   task automatic cyc(bit wr, logic [7:0] a, logic [31:0] d, logic [6:0] dn, string req);
      reg_wr = wr; reg_addr = a; reg_wdata = d; done_pulse = dn;
      @(posedge clk);
      @(negedge clk);
      check_ports(req);
   endtask

   task automatic rd(logic [7:0] a, string req);
      cyc(0, a, 32'h0, 7'h0, req);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n = 0; reg_wr = 0; reg_addr = 8'hF0; reg_wdata = 0; done_pulse = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check_ports("R1");
      rst_n = 1;
      rd(8'hF0, "R1");
      rd(8'hF4, "R1");

      // control word patterns
      cyc(1, 8'hF0, 32'hFFFF_FFFF, 7'h0, "R2");
      rd(8'hF0, "R2");
      cyc(1, 8'hF0, 32'h5A3C_9E71, 7'h0, "R2");
      rd(8'hF0, "R2");

      // force raises the master, force reads 0
      cyc(1, 8'hF4, 32'h00FF_803F, 7'h0, "R3");
      rd(8'hF4, "R8");
      rd(8'hF4, "R7");
      cyc(1, 8'hF4, 32'h0000_0015, 7'h0, "R3");
      rd(8'hF4, "R7");

      // pulse with global enable off
      cyc(0, 8'hF4, 32'h0, 7'h04, "R4");
      rd(8'hF4, "R4");
      // enable channel 2 and global; flag untouched, master rises
      cyc(1, 8'hF4, 32'h0084_0000, 7'h0, "R5");
      rd(8'hF4, "R8");
      // pulse a disabled channel, master stays
      cyc(0, 8'hF4, 32'h0, 7'h21, "R4");
      // ack channel 5 only; channel 0 and 2 keep flags
      cyc(1, 8'hF4, 32'h2084_0000, 7'h0, "R5");
      rd(8'hF4, "R5");
      // ack channel 2, master falls
      cyc(1, 8'hF4, 32'h0484_0000, 7'h0, "R7");
      rd(8'hF4, "R7");
      // pulse while enabled, master rises from pulse alone
      cyc(0, 8'hF4, 32'h0, 7'h04, "R7");
      rd(8'hF4, "R8");
      // same-cycle ack and pulse on channel 3
      cyc(1, 8'hF4, 32'h0888_0000, 7'h08, "R6");
      rd(8'hF4, "R6");
      // clear everything with all ones in the flag field, enables off
      cyc(1, 8'hF4, 32'h7F00_0000, 7'h0, "R5");
      rd(8'hF4, "R5");

      // unmapped offsets
      cyc(1, 8'hF8, 32'hFFFF_FFFF, 7'h0, "R9");
      rd(8'hF8, "R9");
      rd(8'h00, "R9");
      rd(8'hF0, "R9");
      rd(8'hF4, "R9");

      // idle hold
      repeat (4) rd(8'hF4, "R7");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule